// File: doc/BRIEF.md
# ATA Device Task-File and Command Status Unit

This block is the device side of a parallel ATA register window. A host reaches eight byte-wide registers through a three-bit offset, one read or write strobe per cycle. The unit keeps the addressing registers (sector count, three LBA bytes, device/head) as plain storage. It reports progress through a status byte and an error byte, and it drives one interrupt request line.

Two commands are executed. IDENTIFY DEVICE presents 256 words of constant identification data, one word per read of the data register. The data-request bit stays up until the last word has been taken. FLUSH CACHE holds the device busy until an external `flush_done` pulse arrives from the media side. Any other opcode is rejected with an abort error. DMA data movement and the media are outside this block.

The register window has no back-pressure: every strobe is taken in the cycle it is presented. Read data is combinational from the current state, and the side effects of a read (advancing the identify pointer, clearing the interrupt) take effect at the clock edge that ends the read cycle. The host must not assert `host_rd` and `host_wr` together.

Top module: `atadev_taskfile`

## Requirements
- R1: After reset, status reads 0x40 (only DRDY, bit 6), the error register reads 0x00, the data register reads 0x0000 and `intrq` is low.
- R2: Offsets 2, 3, 4, 5 and 6 (sector count, LBA low, LBA mid, LBA high, device) return the last byte written to them. Offset 1 reads the error register, and a write to it does not change what it reads. Offset 7 reads status and takes commands when written.
- R3: After opcode 0xEC is accepted, `intrq` rises and status reads 0x48 (DRDY and DRQ, bit 3) before each of 256 data reads at offset 0. After the 256th read, status reads 0x40. BSY (bit 7) and DRQ are never set together.
- R4: Identify word 0 is 0x0040. Words 10 to 19 hold the 20-character serial text and words 23 to 26 hold the 8-character version text, with the earlier character of each pair in the high byte. Word 85 is 0x0020 (write cache enabled, bit 5). Every other word is 0x0000.
- R5: After opcode 0xE7, status reads 0xC0 (BSY and DRDY) until a `flush_done` pulse. From the next cycle, status reads 0x40 and `intrq` is high. A `flush_done` pulse while no flush is pending has no effect.
- R6: A status read at offset 7 clears `intrq` at the end of that read cycle. If a completion event falls in the same cycle, `intrq` stays high.
- R7: Any opcode other than 0xEC or 0xE7 makes status read 0x41 (DRDY and ERR, bit 0) and the error register read 0x04 (abort, bit 2), and raises `intrq`. The next accepted command clears the abort bit.
- R8: A write to offset 7 while BSY is set is ignored.
- R9: A read at offset 0 outside an identify transfer returns 0x0000 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Register offset 0..7 |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_wdata | input | 8 | Write byte |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_rdata | output | 16 | Read data; upper byte is zero except at offset 0 |
| flush_done | input | 1 | One-cycle completion pulse for a pending flush |
| intrq | output | 1 | Interrupt request, level |

## Verification
The bench drives two events into the same cycle: a `flush_done` pulse and a status read that also clears the interrupt. It issues a flush, then asserts both strobes together. The read must return 0xC0, since it sees the state before the edge, and `intrq` must still be high afterwards. Only a second status read may return 0x40 and drop `intrq`. A command write on a busy flush is also tested: it is placed just before completion, and after release the data register must read zero, proving no identify started.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

  localparam logic [2:0] OFF_DATA   = 3'd0;
  localparam logic [2:0] OFF_ERROR  = 3'd1;
  localparam logic [2:0] OFF_COUNT  = 3'd2;
  localparam logic [2:0] OFF_DEVICE = 3'd6;
  localparam logic [2:0] OFF_STATUS = 3'd7;

  localparam logic [7:0] ST_BSY  = 8'h80;
  localparam logic [7:0] ST_DRDY = 8'h40;
  localparam logic [7:0] ST_DRQ  = 8'h08;
  localparam logic [7:0] ST_ERR  = 8'h01;
  localparam logic [7:0] ER_ABRT = 8'h04;

  localparam logic [7:0] OPC_IDENTIFY = 8'hEC;
  localparam logic [7:0] OPC_FLUSH    = 8'hE7;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_IDENT = 2'd1,
    PH_FLUSH = 2'd2
  } tf_phase_t;

endpackage

// File: rtl/ata_id_rom.sv
module ata_id_rom #(
  parameter int ID_WORDS  = 256,
  parameter int SER_CHARS = 20,
  parameter int VER_CHARS = 8,
  parameter logic [8*SER_CHARS-1:0] SERIAL_TXT  = "TFU-DISK-SN-00000042",
  parameter logic [8*VER_CHARS-1:0] VERSION_TXT = "FW-0.9.3",
  localparam int IDX_W = $clog2(ID_WORDS)
) (
  input  logic [IDX_W-1:0] idx,
  output logic [15:0]      word
);
  localparam int SER_BASE  = 10;
  localparam int SER_WORDS = SER_CHARS / 2;
  localparam int VER_BASE  = 23;
  localparam int VER_WORDS = VER_CHARS / 2;
  localparam int CAP_WORD  = 85;

  logic [15:0] rom_w [ID_WORDS];

  for (genvar g = 0; g < ID_WORDS; g++) begin : g_word
    if (g >= SER_BASE && g < SER_BASE + SER_WORDS) begin : g_ser
      assign rom_w[g] = SERIAL_TXT[8*SER_CHARS-1-16*(g-SER_BASE) -: 16];
    end else if (g >= VER_BASE && g < VER_BASE + VER_WORDS) begin : g_ver
      assign rom_w[g] = VERSION_TXT[8*VER_CHARS-1-16*(g-VER_BASE) -: 16];
    end else if (g == CAP_WORD) begin : g_cap
      assign rom_w[g] = 16'h0020;
    end else if (g == 0) begin : g_cfg
      assign rom_w[g] = 16'h0040;
    end else begin : g_zero
      assign rom_w[g] = 16'h0000;
    end
  end

  assign word = rom_w[idx];

endmodule

// File: rtl/ata_tf_shadow.sv
module ata_tf_shadow #(
  parameter int FIRST = 2,
  parameter int COUNT = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data
);
  logic [7:0] regs_q [COUNT];

  for (genvar g = 0; g < COUNT; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs_q[g] <= 8'h00;
      end else if (wr_en && addr == 3'(FIRST + g)) begin
        regs_q[g] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < COUNT; i++) begin
      if (addr == 3'(FIRST + i)) rd_data = regs_q[i];
    end
  end

endmodule

// File: rtl/ata_cmd_ctrl.sv
module ata_cmd_ctrl
  import ata_tf_pkg::*;
#(
  parameter int ID_WORDS = 256,
  localparam int IDX_W = $clog2(ID_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [7:0]       cmd_opc,
  input  logic             data_rd,
  input  logic             status_rd,
  input  logic             flush_done,
  output logic [7:0]       status,
  output logic             abort,
  output logic             in_ident,
  output logic [IDX_W-1:0] word_idx,
  output logic             irq
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_WORDS - 1);

  tf_phase_t        ph_q, ph_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             abort_q, abort_n;
  logic             irq_q, irq_n;
  logic             raise, taken;

  always_comb begin
    ph_n    = ph_q;
    idx_n   = idx_q;
    abort_n = abort_q;
    raise   = 1'b0;
    taken   = 1'b0;
    unique case (ph_q)
      PH_FLUSH: begin
        if (flush_done) begin
          ph_n  = PH_IDLE;
          raise = 1'b1;
        end
      end
      default: begin
        if (cmd_wr) begin
          taken = 1'b1;
          if (cmd_opc == OPC_IDENTIFY) begin
            ph_n    = PH_IDENT;
            idx_n   = '0;
            abort_n = 1'b0;
            raise   = 1'b1;
          end else if (cmd_opc == OPC_FLUSH) begin
            ph_n    = PH_FLUSH;
            abort_n = 1'b0;
          end else begin
            ph_n    = PH_IDLE;
            abort_n = 1'b1;
            raise   = 1'b1;
          end
        end else if (ph_q == PH_IDENT && data_rd) begin
          idx_n = idx_q + 1'b1;
          if (idx_q == LAST_IDX) ph_n = PH_IDLE;
        end
      end
    endcase
    if (raise)                   irq_n = 1'b1;
    else if (status_rd || taken) irq_n = 1'b0;
    else                         irq_n = irq_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      idx_q   <= '0;
      abort_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      ph_q    <= ph_n;
      idx_q   <= idx_n;
      abort_q <= abort_n;
      irq_q   <= irq_n;
    end
  end

  always_comb begin
    status = ST_DRDY;
    if (ph_q == PH_FLUSH) status = status | ST_BSY;
    if (ph_q == PH_IDENT) status = status | ST_DRQ;
    if (ph_q == PH_IDLE && abort_q) status = status | ST_ERR;
  end

  assign abort    = abort_q;
  assign in_ident = (ph_q == PH_IDENT);
  assign word_idx = idx_q;
  assign irq      = irq_q;

endmodule

// File: rtl/atadev_taskfile.sv
module atadev_taskfile
  import ata_tf_pkg::*;
#(
  parameter int ID_WORDS  = 256,
  parameter int SER_CHARS = 20,
  parameter int VER_CHARS = 8,
  parameter logic [8*SER_CHARS-1:0] SERIAL_TXT  = "TFU-DISK-SN-00000042",
  parameter logic [8*VER_CHARS-1:0] VERSION_TXT = "FW-0.9.3"
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  host_addr,
  input  logic        host_wr,
  input  logic [7:0]  host_wdata,
  input  logic        host_rd,
  output logic [15:0] host_rdata,
  input  logic        flush_done,
  output logic        intrq
);
  localparam int IDX_W    = $clog2(ID_WORDS);
  localparam int SH_FIRST = int'(OFF_COUNT);
  localparam int SH_COUNT = int'(OFF_DEVICE) - int'(OFF_COUNT) + 1;

  logic [7:0]       status_q;
  logic             abort;
  logic             in_ident;
  logic [IDX_W-1:0] word_idx;
  logic [15:0]      id_word;
  logic [7:0]       shadow_rd;
  logic             shadow_wr;

  assign shadow_wr = host_wr && host_addr >= OFF_COUNT && host_addr <= OFF_DEVICE;

  ata_tf_shadow #(.FIRST(SH_FIRST), .COUNT(SH_COUNT)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (shadow_wr),
    .addr    (host_addr),
    .wr_data (host_wdata),
    .rd_data (shadow_rd)
  );

  ata_cmd_ctrl #(.ID_WORDS(ID_WORDS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (host_wr && host_addr == OFF_STATUS),
    .cmd_opc    (host_wdata),
    .data_rd    (host_rd && host_addr == OFF_DATA),
    .status_rd  (host_rd && host_addr == OFF_STATUS),
    .flush_done (flush_done),
    .status     (status_q),
    .abort      (abort),
    .in_ident   (in_ident),
    .word_idx   (word_idx),
    .irq        (intrq)
  );

  ata_id_rom #(
    .ID_WORDS    (ID_WORDS),
    .SER_CHARS   (SER_CHARS),
    .VER_CHARS   (VER_CHARS),
    .SERIAL_TXT  (SERIAL_TXT),
    .VERSION_TXT (VERSION_TXT)
  ) u_rom (
    .idx  (word_idx),
    .word (id_word)
  );

  always_comb begin
    unique case (host_addr)
      OFF_DATA:   host_rdata = in_ident ? id_word : 16'h0000;
      OFF_ERROR:  host_rdata = {8'h00, abort ? ER_ABRT : 8'h00};
      OFF_STATUS: host_rdata = {8'h00, status_q};
      default:    host_rdata = {8'h00, shadow_rd};
    endcase
  end

endmodule

// File: rtl/ata_tf_chk.sv
module ata_tf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] host_addr,
  input logic       host_wr,
  input logic [7:0] host_wdata,
  input logic       host_rd,
  input logic       flush_done,
  input logic       intrq,
  input logic [7:0] stat
);
  logic stat_rd, cmd_wr, bad_opc;
  assign stat_rd = host_rd && host_addr == 3'd7;
  assign cmd_wr  = host_wr && host_addr == 3'd7;
  assign bad_opc = host_wdata != 8'hEC && host_wdata != 8'hE7;

  // R3
  bsy_drq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat[7] && stat[3]));

  // R3
  drq_drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat[3]) |-> $past(host_rd && host_addr == 3'd0) || $past(cmd_wr));

  // R5
  flush_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat[7] && flush_done |=> !stat[7] && stat[6] && intrq);

  // R6
  status_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !host_wr && !(stat[7] && flush_done) |=> !intrq);

  // R7
  abort_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !host_rd && !stat[7] && bad_opc |=> stat == 8'h41 && intrq);

  // R8
  busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat[7] && cmd_wr && !flush_done |=> stat[7]);

endmodule

bind atadev_taskfile ata_tf_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_addr  (host_addr),
  .host_wr    (host_wr),
  .host_wdata (host_wdata),
  .host_rd    (host_rd),
  .flush_done (flush_done),
  .intrq      (intrq),
  .stat       (status_q)
);

// File: tb/atadev_taskfile_test.sv
module atadev_taskfile_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  host_addr = '0;
  logic        host_wr = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic        host_rd = 1'b0;
  logic [15:0] host_rdata;
  logic        flush_done = 1'b0;
  logic        intrq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  atadev_taskfile uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .flush_done(flush_done), .intrq(intrq)
  );

  // {write, offset, write byte, expected read byte}
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b1, 3'd2, 8'h5A, 8'h00},  // R2
    {1'b1, 3'd3, 8'h11, 8'h00},
    {1'b1, 3'd4, 8'h22, 8'h00},
    {1'b1, 3'd5, 8'h33, 8'h00},
    {1'b1, 3'd6, 8'h50, 8'h00},
    {1'b1, 3'd1, 8'h77, 8'h00},
    {1'b0, 3'd2, 8'h00, 8'h5A},
    {1'b0, 3'd3, 8'h00, 8'h11},
    {1'b0, 3'd4, 8'h00, 8'h22},
    {1'b0, 3'd5, 8'h00, 8'h33},
    {1'b0, 3'd6, 8'h00, 8'h50},
    {1'b0, 3'd1, 8'h00, 8'h00},
    {1'b0, 3'd7, 8'h00, 8'h40},
    {1'b1, 3'd7, 8'h00, 8'h00},  // R7 unknown opcode
    {1'b0, 3'd1, 8'h00, 8'h04},
    {1'b0, 3'd7, 8'h00, 8'h41}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    flush_done = 1'b1;
    @(negedge clk);
    flush_done = 1'b0;
  endtask

  function automatic logic [15:0] exp_word(input int i);
    string ser = "TFU-DISK-SN-00000042";
    string ver = "FW-0.9.3";
    if (i == 0) return 16'h0040;
    if (i == 85) return 16'h0020;
    if (i >= 10 && i < 20) return {ser[2*(i-10)], ser[2*(i-10)+1]};
    if (i >= 23 && i < 27) return {ver[2*(i-23)], ver[2*(i-23)+1]};
    return 16'h0000;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check("R1 intrq", 16'(intrq), 16'h0);
    do_rd(3'd7, r); check("R1 status", r, 16'h0040);
    do_rd(3'd1, r); check("R1 error", r, 16'h0000);
    do_rd(3'd0, r); check("R1 data", r, 16'h0000);

    // table walk (R2, R7)
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][19]) begin
        do_wr(VEC[v][18:16], VEC[v][15:8]);
        if (v == 13) check("R7 intrq after abort", 16'(intrq), 16'h1);
      end else begin
        do_rd(VEC[v][18:16], r);
        check((v == 14 || v == 15) ? "R7 table" : "R2 table", r, {8'h00, VEC[v][7:0]});
      end
    end
    check("R6 intrq cleared by status read", 16'(intrq), 16'h0);

    // R9 data read outside identify
    do_rd(3'd0, r); check("R9 data idle", r, 16'h0000);
    do_rd(3'd7, r); check("R9 status unchanged", r, 16'h0041);

    // R3 / R4 identify transfer; also clears abort (R7)
    do_wr(3'd7, 8'hEC);
    check("R3 intrq on identify", 16'(intrq), 16'h1);
    do_rd(3'd1, r); check("R7 abort cleared", r, 16'h0000);
    for (int w = 0; w < 256; w++) begin
      do_rd(3'd7, r); check("R3 status during identify", r, 16'h0048);
      do_rd(3'd0, r); check("R4 identify word", r, exp_word(w));
    end
    check("R6 intrq after status reads", 16'(intrq), 16'h0);
    do_rd(3'd7, r); check("R3 status after last word", r, 16'h0040);
    do_rd(3'd0, r); check("R9 data after identify", r, 16'h0000);

    // R5 stray completion ignored
    pulse_done();
    check("R5 stray done intrq", 16'(intrq), 16'h0);
    do_rd(3'd7, r); check("R5 stray done status", r, 16'h0040);

    // R5 / R8 flush with busy command write
    do_wr(3'd7, 8'hE7);
    do_rd(3'd7, r); check("R5 busy status", r, 16'h00C0);
    do_wr(3'd7, 8'hEC);
    do_rd(3'd7, r); check("R8 still busy", r, 16'h00C0);
    check("R8 no intrq", 16'(intrq), 16'h0);
    pulse_done();
    check("R5 intrq on release", 16'(intrq), 16'h1);
    do_rd(3'd0, r); check("R8 no identify started", r, 16'h0000);
    do_rd(3'd7, r); check("R5 status after release", r, 16'h0040);
    check("R6 intrq cleared", 16'(intrq), 16'h0);

    // R6 completion and status read in the same cycle
    do_wr(3'd7, 8'hE7);
    @(negedge clk);
    host_addr = 3'd7; host_rd = 1'b1; flush_done = 1'b1;
    #1 r = host_rdata;
    @(negedge clk);
    host_rd = 1'b0; flush_done = 1'b0;
    check("R6 same-cycle read value", r, 16'h00C0);
    check("R6 intrq survives same-cycle read", 16'(intrq), 16'h1);
    do_rd(3'd7, r); check("R6 status after", r, 16'h0040);
    check("R6 intrq cleared later", 16'(intrq), 16'h0);

    finish_run();
  end

endmodule